// File: doc/BRIEF.md
# Single-Slope PWM Timer with Two Compare Channels

This block is an 8-bit up-counter that runs from zero to its top value and then starts again at zero. It advances only on clocks where a count-enable tick is present, so an external divider sets the PWM frequency. Two compare channels watch the counter. Each channel turns the count into a pulse-width-modulated pin according to its own compare value and its own 2-bit output mode.

Each channel takes a compare value and a mode from a write strobe and a shared data bus. A new compare value goes into a shadow register first. It moves to the active register only at the step from the top count back to zero, so a running period is never cut short. A mode write takes effect on the next clock.

In the normal-polarity mode the pin is high for counts 0 through the active compare value and low for the rest of the period. The inverted mode gives the exact complement. The two remaining codes leave the pin low. For each channel a match flag shows, cycle by cycle, that the counter equals that channel's active compare value.

Top module: `fastpwm_timer`

## Requirements
- R1: After reset the count is 0, every active and shadow compare value is 0, every mode is 0, both pins are low and both match flags are high.
- R2: The count goes up by exactly one on a clock where `tick_i` is high and holds its value on every other clock.
- R3: On a tick at count 255 the count goes to 0.
- R4: `match_o[c]` is high exactly when the current count equals channel c's active compare value.
- R5: With mode code 2 (normal polarity) the pin of a channel with active compare value V is high for counts 0 to V and low for counts V+1 to 255.
- R6: With mode code 3 (inverted) the pin is low for counts 0 to V and high for counts V+1 to 255.
- R7: With mode code 0 or code 1 the pin is low at every count.
- R8: A compare write changes only the shadow value. The shadow value moves to the active register on the tick that wraps the count from 255 to 0, and a write made in that same clock is the value that moves. Until then the pin and the match flag follow the old value.
- R9: With mode 2, an active value of 0 gives a pin that is high only at count 0, and an active value of 255 gives a pin that is high at all 256 counts.
- R10: A write addressed to one channel changes neither the compare value nor the mode of the other channel.
- R11: A mode write changes the pin from the next clock on, in the middle of a period, with no wait for the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable for this clock |
| cmp_wr_i | input | NUM_CH | Per-channel strobe that writes the compare shadow |
| cmp_wdata_i | input | CNT_W | Compare value to write |
| mode_wr_i | input | NUM_CH | Per-channel strobe that writes the output mode |
| mode_wdata_i | input | 2 | Mode code: 0 off, 1 off, 2 normal polarity, 3 inverted |
| count_o | output | CNT_W | Current counter value |
| match_o | output | NUM_CH | Counter equals the channel's active compare value |
| pwm_o | output | NUM_CH | PWM pins |

## Verification
The bench measures the high time over whole periods at the extreme compare values 0 and 255. An off-by-one in the set/clear ordering would give 0 or 255 high counts there instead of 1 and 256. It writes a compare value in the middle of a period and checks that the pin keeps the old width until the wrap; a design without the shadow register would clip that period. It also changes the mode mid-period, and writes one channel while watching the other, to catch a pin that only updates at the wrap or a decode that writes the wrong channel. Irregular tick patterns catch a counter that advances on untimed clocks.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
package pwm_timer_pkg;

    // Output mode codes; the pin decode depends on these values.
    typedef enum logic [1:0] {
        CMP_OFF    = 2'd0,
        CMP_RSVD   = 2'd1,
        CMP_NONINV = 2'd2,
        CMP_INV    = 2'd3
    } cmp_mode_e;

endpackage

// File: rtl/pwm_count.sv
`timescale 1ns/1ps
module pwm_count #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    output logic [W-1:0] count_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] TOP = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tick_i) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count_o = s_q.cnt;
    assign wrap_o  = tick_i && (s_q.cnt == TOP);

endmodule

// File: rtl/pwm_pin_mux.sv
`timescale 1ns/1ps
module pwm_pin_mux
    import pwm_timer_pkg::*;
(
    input  cmp_mode_e mode_i,
    input  logic      level_i,
    output logic      pin_o
);
    always_comb begin
        unique case (mode_i)
            CMP_NONINV: pin_o = level_i;
            CMP_INV:    pin_o = ~level_i;
            default:    pin_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
    import pwm_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  logic [W-1:0] count_i,
    input  logic         wrap_i,
    input  logic         cmp_wr_i,
    input  logic [W-1:0] cmp_wdata_i,
    input  logic         mode_wr_i,
    input  logic [1:0]   mode_wdata_i,
    output logic         pwm_o,
    output logic         match_o,
    output logic [W-1:0] cmp_act_o,
    output logic [1:0]   mode_o
);
    typedef struct packed {
        logic [W-1:0] shadow;
        logic [W-1:0] active;
        cmp_mode_e    mode;
        logic         level;   // normal-polarity waveform level
    } ch_state_t;

    ch_state_t s_d, s_q;
    logic      hit;

    assign hit = (count_i == s_q.active);

    always_comb begin
        s_d = s_q;
        if (cmp_wr_i) begin
            s_d.shadow = cmp_wdata_i;
        end
        if (mode_wr_i) begin
            s_d.mode = cmp_mode_e'(mode_wdata_i);
        end
        if (wrap_i) begin
            // bottom of the next period: load new compare, raise level
            s_d.active = s_d.shadow;
            s_d.level  = 1'b1;
        end else if (tick_i && hit) begin
            s_d.level  = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.shadow <= '0;
            s_q.active <= '0;
            s_q.mode   <= CMP_OFF;
            s_q.level  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    pwm_pin_mux u_mux (
        .mode_i  (s_q.mode),
        .level_i (s_q.level),
        .pin_o   (pwm_o)
    );

    assign match_o   = hit;
    assign cmp_act_o = s_q.active;
    assign mode_o    = s_q.mode;

endmodule

// File: rtl/fastpwm_timer.sv
`timescale 1ns/1ps
module fastpwm_timer #(
    parameter int CNT_W  = 8,
    parameter int NUM_CH = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [NUM_CH-1:0] cmp_wr_i,
    input  logic [CNT_W-1:0]  cmp_wdata_i,
    input  logic [NUM_CH-1:0] mode_wr_i,
    input  logic [1:0]        mode_wdata_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [NUM_CH-1:0] match_o,
    output logic [NUM_CH-1:0] pwm_o
);
    localparam int ACT_W  = CNT_W * NUM_CH;
    localparam int MODE_W = 2 * NUM_CH;

    logic [CNT_W-1:0]  count;
    logic              wrap;
    logic [ACT_W-1:0]  act_flat;
    logic [MODE_W-1:0] mode_flat;

    pwm_count #(.W(CNT_W)) u_count (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .count_o (count),
        .wrap_o  (wrap)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_channel #(.W(CNT_W)) u_ch (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .tick_i       (tick_i),
            .count_i      (count),
            .wrap_i       (wrap),
            .cmp_wr_i     (cmp_wr_i[c]),
            .cmp_wdata_i  (cmp_wdata_i),
            .mode_wr_i    (mode_wr_i[c]),
            .mode_wdata_i (mode_wdata_i),
            .pwm_o        (pwm_o[c]),
            .match_o      (match_o[c]),
            .cmp_act_o    (act_flat[c*CNT_W +: CNT_W]),
            .mode_o       (mode_flat[2*c +: 2])
        );
    end

    assign count_o = count;

endmodule

// File: rtl/pwm_timer_chk.sv
`timescale 1ns/1ps
module pwm_timer_chk #(
    parameter int W = 8,
    parameter int N = 2
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           tick_i,
    input logic [W-1:0]   count_i,
    input logic [N-1:0]   pwm_i,
    input logic [W*N-1:0] act_i,
    input logic [2*N-1:0] mode_i
);
    localparam logic [W-1:0] TOP = '1;

    // R2
    count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(count_i));

    // R2
    count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && count_i != TOP) |=> (count_i - $past(count_i)) == W'(1));

    // R3
    count_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && count_i == TOP) |=> count_i == '0);

    for (genvar c = 0; c < N; c++) begin : g_ch
        // R8
        act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(tick_i && count_i == TOP) |=> $stable(act_i[c*W +: W]));

        // R5
        noninv_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (tick_i && count_i == act_i[c*W +: W] && count_i != TOP)
            |=> (mode_i[2*c +: 2] != 2'd2 || !pwm_i[c]));

        // R6
        inv_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (tick_i && count_i == act_i[c*W +: W] && count_i != TOP)
            |=> (mode_i[2*c +: 2] != 2'd3 || pwm_i[c]));

        // R7
        off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mode_i[2*c +: 2] == 2'd0 || mode_i[2*c +: 2] == 2'd1) |-> !pwm_i[c]);
    end

endmodule

bind fastpwm_timer pwm_timer_chk #(.W(CNT_W), .N(NUM_CH)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .count_i (count_o),
    .pwm_i   (pwm_o),
    .act_i   (act_flat),
    .mode_i  (mode_flat)
);

// File: tb/fastpwm_timer_test.sv
`timescale 1ns/1ps
module fastpwm_timer_test;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       tick_i = 1'b0;
    logic [1:0] cmp_wr_i = '0;
    logic [7:0] cmp_wdata_i = '0;
    logic [1:0] mode_wr_i = '0;
    logic [1:0] mode_wdata_i = '0;
    logic [7:0] count_o;
    logic [1:0] match_o;
    logic [1:0] pwm_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit live = 0;

    // behavioural reference state
    int m_cnt = 0;
    int m_buf[2] = '{0, 0};
    int m_act[2] = '{0, 0};
    int m_mode[2] = '{0, 0};
    int hi[2];

    always #2.5 clk_i = ~clk_i;

    fastpwm_timer uut (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
        .cmp_wr_i(cmp_wr_i), .cmp_wdata_i(cmp_wdata_i),
        .mode_wr_i(mode_wr_i), .mode_wdata_i(mode_wdata_i),
        .count_o(count_o), .match_o(match_o), .pwm_o(pwm_o)
    );

    task automatic chk(string tag, int actual, int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
        end
    endtask

    function automatic int exp_pin(int c);
        int raw = (m_cnt <= m_act[c]) ? 1 : 0;
        if (m_mode[c] == 2) return raw;
        if (m_mode[c] == 3) return 1 - raw;
        return 0;
    endfunction

    always @(posedge clk_i) begin
        if (!rst_ni) begin
            m_cnt = 0;
            for (int c = 0; c < 2; c++) begin
                m_buf[c] = 0; m_act[c] = 0; m_mode[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                if (cmp_wr_i[c])  m_buf[c] = cmp_wdata_i;
                if (mode_wr_i[c]) m_mode[c] = mode_wdata_i;
            end
            if (tick_i) begin
                if (m_cnt == 255) begin
                    m_cnt = 0;
                    for (int c = 0; c < 2; c++) m_act[c] = m_buf[c];
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
        end
    end

    always @(negedge clk_i) begin
        if (live) begin
            chk("R2/R3 count", count_o, m_cnt);
            for (int c = 0; c < 2; c++) begin
                chk("R4 match", match_o[c], (m_cnt == m_act[c]) ? 1 : 0);
                if (m_mode[c] == 2)      chk("R5 pin normal", pwm_o[c], exp_pin(c));
                else if (m_mode[c] == 3) chk("R6 pin inverted", pwm_o[c], exp_pin(c));
                else                     chk("R7 pin off", pwm_o[c], exp_pin(c));
            end
        end
    end

    task automatic wr_cmp(int c, int v);
        cmp_wr_i[c] = 1'b1; cmp_wdata_i = 8'(v);
        @(negedge clk_i);
        cmp_wr_i = '0;
    endtask

    task automatic wr_mode(int c, int v);
        mode_wr_i[c] = 1'b1; mode_wdata_i = 2'(v);
        @(negedge clk_i);
        mode_wr_i = '0;
    endtask

    task automatic seek_zero();
        tick_i = 1'b1;
        do @(negedge clk_i); while (count_o != 8'd0);
    endtask

    task automatic measure();
        seek_zero();
        hi[0] = 0; hi[1] = 0;
        for (int k = 0; k < 256; k++) begin
            hi[0] += pwm_o[0];
            hi[1] += pwm_o[1];
            @(negedge clk_i);
        end
    endtask

    task automatic wait_count(int v);
        while (count_o != 8'(v)) @(negedge clk_i);
    endtask

    initial begin
        #500000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        // R1 reset state
        chk("R1 count", count_o, 0);
        chk("R1 pwm", pwm_o, 0);
        chk("R1 match", match_o, 3);
        live = 1;

        // R2 tick five times, then hold
        tick_i = 1'b1;
        repeat (5) @(negedge clk_i);
        tick_i = 1'b0;
        chk("R2 after five ticks", count_o, 5);
        repeat (5) @(negedge clk_i);
        chk("R2 held without tick", count_o, 5);

        // R5 / R6 basic widths
        wr_cmp(0, 8'h1F); wr_cmp(1, 8'h80);
        wr_mode(0, 2); wr_mode(1, 3);
        measure();
        chk("R5 normal high count cmp 0x1F", hi[0], 32);
        chk("R6 inverted high count cmp 0x80", hi[1], 127);

        // R8 mid-period write is deferred
        repeat (10) @(negedge clk_i);
        wr_cmp(0, 5);
        wait_count(20);
        chk("R8 old compare still shapes pin", pwm_o[0], 1);
        chk("R8 old compare still drives match", match_o[0], 0);
        measure();
        chk("R8 new compare after wrap", hi[0], 6);
        chk("R10 other channel untouched", hi[1], 127);

        // R11 mode change mid-period
        wait_count(10);
        chk("R11 inverted before change", pwm_o[1], 0);
        wr_mode(1, 2);
        chk("R11 normal right after change", pwm_o[1], 1);

        // R9 extreme compare values
        wr_cmp(0, 0); wr_cmp(1, 8'hFF);
        wr_mode(0, 2);
        measure();
        chk("R9 compare 0 high count", hi[0], 1);
        chk("R9 compare 255 high count", hi[1], 256);

        // R7 off codes
        wr_mode(0, 0); wr_mode(1, 1);
        measure();
        chk("R7 code 0 high count", hi[0], 0);
        chk("R7 code 1 high count", hi[1], 0);

        // R10 channel independence
        wr_cmp(0, 8'h40); wr_cmp(1, 8'h10);
        wr_mode(0, 2); wr_mode(1, 2);
        measure();
        chk("R10 ch0 width", hi[0], 65);
        chk("R10 ch1 width", hi[1], 17);
        wr_cmp(1, 8'h20); wr_mode(1, 3);
        measure();
        chk("R10 ch0 unchanged by ch1 write", hi[0], 65);
        chk("R10 ch1 new setting", hi[1], 223);

        // R2 irregular tick pattern, reference compares every clock
        for (int k = 0; k < 900; k++) begin
            tick_i = ((k % 3) != 0) && ((k % 7) != 2);
            @(negedge clk_i);
        end
        tick_i = 1'b0;
        repeat (2) @(negedge clk_i);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule